// File: doc/BRIEF.md
# HDLC Frame Encapsulation Engine

This block takes the payload of one received voice or data packet, presented as a byte stream with start and end markers, and emits the HDLC-framed version of it as a byte stream ready to be stored in a receive buffer. One engine serves every channel. Each frame is built in this order: an optional fixed-length packet header, copied untouched; an opening flag; the protected region; a closing flag. The protected region holds an optional address/control header, the payload and an optional frame check sequence.

Transparency inside the protected region is chosen by one global mode input. Byte mode escapes flag and escape bytes. Bit mode inserts a zero after every run of five ones. The per-packet options and the mode are captured when the start byte is first presented, and they stay fixed until the frame ends. Output back-pressure propagates to the input through the valid/ready handshakes.

Top module: `hdlc_encap`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `outValid` and `outLast` are 0. With `inValid` low in idle, `inReady` is 0.
- R2: Frame layout. When `pktHdrEn` is set, the frame first carries `PKT_HDR_BYTES` header bytes taken from `pktHdr` (byte 0 = bits [7:0] first), with no transparency applied. Then comes flag 0x7E, then the protected region, then a closing 0x7E. The flags never receive transparency.
- R3: When `addrCtlEn` is set, the protected region begins with `hdlcAddr` and then `hdlcCtrl`, ahead of the payload bytes in their arrival order.
- R4: When `fcsEn` is set, the protected region ends with a CRC-16 over the address/control bytes (if present) and the payload. The CRC uses the reflected polynomial 0x8408, initial value 0xFFFF and final inversion, and is sent low byte first.
- R5: Byte mode (`byteMode`=1). Each protected byte equal to 0x7E or 0x7D becomes the two bytes 0x7D and (byte XOR 0x20). All other bytes pass unchanged.
- R6: Bit mode (`byteMode`=0). The bits of the whole frame are serialised LSB first. A 0 is inserted after every five consecutive 1s of the protected region, counting across byte boundaries. The run count restarts right after the opening flag. The result is repacked LSB first into output bytes.
- R7: Bit mode. The closing flag bits follow the last protected bit directly. A partial final byte is filled with the low bits of 0x7E, bit 0 first.
- R8: `outLast` is 1 on exactly the final byte of each frame, and it is only ever 1 together with `outValid`. After that byte is accepted, `outValid` is 0 in the next cycle.
- R9: While `outValid` is 1 and `outReady` is 0, the output byte and marker hold steady. Under any `outReady` pattern, no byte is lost or duplicated.
- R10: In idle, a byte presented with `inFirst`=0 is accepted (`inReady`=1) and discarded without producing output.
- R11: `byteMode`, the three enables, `pktHdr`, `hdlcAddr` and `hdlcCtrl` are sampled when a start byte is seen in idle. Changes to them during the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteMode | input | 1 | Global transparency mode: 1 byte escaping, 0 bit zero insertion |
| pktHdrEn | input | 1 | Per-packet: emit the leading packet header |
| pktHdr | input | 8*PKT_HDR_BYTES | Packet header bytes, byte 0 in bits [7:0] |
| addrCtlEn | input | 1 | Per-packet: emit the HDLC address/control header |
| hdlcAddr | input | 8 | HDLC address byte |
| hdlcCtrl | input | 8 | HDLC control byte |
| fcsEn | input | 1 | Per-packet: append the frame check sequence |
| inValid | input | 1 | Payload byte valid |
| inReady | output | 1 | Payload byte accepted when high with inValid |
| inData | input | 8 | Payload byte |
| inFirst | input | 1 | Marks the first payload byte of a packet |
| inLast | input | 1 | Marks the last payload byte of a packet |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the output byte |
| outData | output | 8 | Framed output byte |
| outLast | output | 1 | Marks the final byte of a frame |

## Verification
The bench builds the engine with the default three-byte packet header. Its header value contains a 0x7E, so a raw 0x7E outside the protected region can be told apart from an escaped one. It sweeps both transparency modes, all eight option combinations and payload lengths of one to six bytes, under both a permanently ready and a pseudo-randomly stalling sink. The payloads are drawn from flag, escape and long-ones patterns. With these settings the bench reaches escapes in the header and in the FCS, zero insertion across byte boundaries, every pad length of the final byte, and option changes in the middle of a frame.

// File: rtl/hdlc_encap_pkg.sv
package hdlc_encap_pkg;
  localparam int BYTE_W = 8;
  localparam int ACC_W  = 3 * BYTE_W;          // worst-case fill plus one append
  localparam int CNT_W  = $clog2(ACC_W + 1);
  localparam int APP_W  = 2 * BYTE_W;          // widest single append
  localparam int APP_N_W = $clog2(APP_W + 1);
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_BYTE  = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_XOR   = 8'h20;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;
  localparam logic [15:0] CRC_INIT     = 16'hFFFF;

  typedef enum logic [1:0] {SRC_CTL, SRC_IN, SRC_FCSLO, SRC_FCSHI} srcSel_e;
  typedef enum logic [1:0] {APP_RAW, APP_PROT, APP_CLOSE} appKind_e;

  typedef struct packed {
    logic              append;
    appKind_e          kind;
    srcSel_e           src;
    logic [BYTE_W-1:0] ctlByte;
    logic              crcUpd;
    logic              frameStart;
    logic              byteMode;
  } strobe_t;
endpackage

// File: rtl/hdlc_encap_ctrl.sv
module hdlc_encap_ctrl
  import hdlc_encap_pkg::*;
#(
  parameter int PKT_HDR_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          byteMode,
  input  logic                          pktHdrEn,
  input  logic [PKT_HDR_BYTES*BYTE_W-1:0] pktHdr,
  input  logic                          addrCtlEn,
  input  logic [BYTE_W-1:0]             hdlcAddr,
  input  logic [BYTE_W-1:0]             hdlcCtrl,
  input  logic                          fcsEn,
  input  logic                          inValid,
  input  logic                          inFirst,
  input  logic                          inLast,
  output logic                          inReady,
  input  logic                          outReady,
  input  logic                          spaceOk,
  input  logic                          oneByteLeft,
  output logic                          outLast,
  output strobe_t                       stb
);
  localparam int IDX_W = (PKT_HDR_BYTES > 1) ? $clog2(PKT_HDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_HDR_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PHDR, S_OPEN, S_ADDR, S_CTRL, S_BODY, S_FCSL, S_FCSH, S_CLOSE, S_DRAIN
  } state_e;

  state_e state;
  logic [IDX_W-1:0] hdrIdx;
  logic [PKT_HDR_BYTES*BYTE_W-1:0] pktHdrQ;
  logic [BYTE_W-1:0] addrQ, ctrlQ;
  logic hdrOnQ, acOnQ, fcsOnQ, modeQ;

  always_comb begin
    stb = '{append: 1'b0, kind: APP_RAW, src: SRC_CTL, ctlByte: '0,
            crcUpd: 1'b0, frameStart: 1'b0, byteMode: modeQ};
    inReady = 1'b0;
    outLast = (state == S_DRAIN) && oneByteLeft;
    case (state)
      S_IDLE:  inReady = inValid && !inFirst;
      S_PHDR: begin
        stb.append  = spaceOk;
        stb.ctlByte = pktHdrQ[hdrIdx*BYTE_W +: BYTE_W];
      end
      S_OPEN: begin
        stb.append     = spaceOk;
        stb.ctlByte    = FLAG_BYTE;
        stb.frameStart = 1'b1;
      end
      S_ADDR, S_CTRL: begin
        stb.append  = spaceOk;
        stb.kind    = APP_PROT;
        stb.ctlByte = (state == S_ADDR) ? addrQ : ctrlQ;
        stb.crcUpd  = 1'b1;
      end
      S_BODY: begin
        inReady    = spaceOk;
        stb.append = spaceOk && inValid;
        stb.kind   = APP_PROT;
        stb.src    = SRC_IN;
        stb.crcUpd = 1'b1;
      end
      S_FCSL, S_FCSH: begin
        stb.append = spaceOk;
        stb.kind   = APP_PROT;
        stb.src    = (state == S_FCSL) ? SRC_FCSLO : SRC_FCSHI;
      end
      S_CLOSE: begin
        stb.append = spaceOk;
        stb.kind   = APP_CLOSE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      hdrIdx  <= '0;
      pktHdrQ <= '0;
      addrQ   <= '0;
      ctrlQ   <= '0;
      hdrOnQ  <= 1'b0;
      acOnQ   <= 1'b0;
      fcsOnQ  <= 1'b0;
      modeQ   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (inValid && inFirst) begin
          pktHdrQ <= pktHdr;
          addrQ   <= hdlcAddr;
          ctrlQ   <= hdlcCtrl;
          hdrOnQ  <= pktHdrEn;
          acOnQ   <= addrCtlEn;
          fcsOnQ  <= fcsEn;
          modeQ   <= byteMode;
          hdrIdx  <= '0;
          state   <= pktHdrEn ? S_PHDR : S_OPEN;
        end
        S_PHDR: if (spaceOk) begin
          hdrIdx <= hdrIdx + 1'b1;
          if (hdrIdx == LAST_IDX) state <= S_OPEN;
        end
        S_OPEN:  if (spaceOk) state <= acOnQ ? S_ADDR : S_BODY;
        S_ADDR:  if (spaceOk) state <= S_CTRL;
        S_CTRL:  if (spaceOk) state <= S_BODY;
        S_BODY:  if (spaceOk && inValid && inLast) state <= fcsOnQ ? S_FCSL : S_CLOSE;
        S_FCSL:  if (spaceOk) state <= S_FCSH;
        S_FCSH:  if (spaceOk) state <= S_CLOSE;
        S_CLOSE: if (spaceOk) state <= S_DRAIN;
        S_DRAIN: if (oneByteLeft && outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic unusedHdrOn;
  assign unusedHdrOn = hdrOnQ;
endmodule

// File: rtl/hdlc_encap_dp.sv
module hdlc_encap_dp
  import hdlc_encap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] inData,
  input  logic              outReady,
  output logic              spaceOk,
  output logic              oneByteLeft,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic [CNT_W-1:0]  fillLevel
);
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       onesRun;
  logic [15:0]      crcQ;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [BYTE_W-1:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REF;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // returns {onesOut, bitCount, bits}
  function automatic logic [3+APP_N_W+APP_W-1:0] stuffByte(input logic [BYTE_W-1:0] b,
                                                         input logic [2:0] onesIn);
    logic [APP_W-1:0]   v;
    logic [APP_N_W-1:0] n;
    logic [2:0]         ones;
    v = '0;
    n = '0;
    ones = onesIn;
    for (int i = 0; i < BYTE_W; i++) begin
      v[n[3:0]] = b[i];
      n = n + 1'b1;
      if (b[i]) begin
        if (ones == 3'd4) begin
          v[n[3:0]] = 1'b0;
          n = n + 1'b1;
          ones = '0;
        end else begin
          ones = ones + 1'b1;
        end
      end else begin
        ones = '0;
      end
    end
    return {ones, n, v};
  endfunction

  logic                 pop;
  logic [BYTE_W-1:0]    selByte;
  logic [15:0]          fcs;
  logic [APP_W-1:0]     appBits;
  logic [APP_N_W-1:0]   appN;
  logic [2:0]           onesNext;
  logic [2:0]           padLen;
  logic [CNT_W-1:0]     base;
  logic [ACC_W-1:0]     accAdd;
  logic [3+APP_N_W+APP_W-1:0] stuffed;

  assign outValid    = cnt >= CNT_W'(BYTE_W);
  assign oneByteLeft = cnt == CNT_W'(BYTE_W);
  assign outData     = acc[BYTE_W-1:0];
  assign fillLevel   = cnt;
  assign pop         = outValid && outReady;
  assign spaceOk     = (cnt < CNT_W'(BYTE_W)) || ((cnt < CNT_W'(2*BYTE_W)) && outReady);
  assign fcs         = ~crcQ;
  assign base        = pop ? cnt - CNT_W'(BYTE_W) : cnt;
  assign padLen      = 3'(4'd8 - {1'b0, cnt[2:0]});
  assign stuffed     = stuffByte(selByte, onesRun);

  always_comb begin
    case (stb.src)
      SRC_IN:    selByte = inData;
      SRC_FCSLO: selByte = fcs[7:0];
      SRC_FCSHI: selByte = fcs[15:8];
      default:   selByte = stb.ctlByte;
    endcase
  end

  always_comb begin
    appBits  = {{(APP_W-BYTE_W){1'b0}}, selByte};
    appN     = APP_N_W'(BYTE_W);
    onesNext = onesRun;
    case (stb.kind)
      APP_PROT: begin
        if (stb.byteMode) begin
          if (selByte == FLAG_BYTE || selByte == ESC_BYTE) begin
            appBits = {selByte ^ ESC_XOR, ESC_BYTE};
            appN    = APP_N_W'(2*BYTE_W);
          end
        end else begin
          {onesNext, appN, appBits} = stuffed;
        end
      end
      APP_CLOSE: begin
        appBits = {FLAG_BYTE & ((8'd1 << padLen) - 8'd1), FLAG_BYTE};
        appN    = APP_N_W'(BYTE_W) + APP_N_W'(padLen);
      end
      default: ;
    endcase
    accAdd = ACC_W'(appBits) << base;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      cnt     <= '0;
      onesRun <= '0;
      crcQ    <= CRC_INIT;
    end else begin
      acc <= (pop ? (acc >> BYTE_W) : acc) | (stb.append ? accAdd : '0);
      cnt <= base + (stb.append ? CNT_W'(appN) : '0);
      if (stb.append && stb.frameStart) begin
        onesRun <= '0;
        crcQ    <= CRC_INIT;
      end else if (stb.append) begin
        if (stb.kind == APP_PROT && !stb.byteMode) onesRun <= onesNext;
        if (stb.crcUpd) crcQ <= crcStep(crcQ, selByte);
      end
    end
  end
endmodule

// File: rtl/hdlc_encap.sv
module hdlc_encap
  import hdlc_encap_pkg::*;
#(
  parameter int PKT_HDR_BYTES = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            byteMode,
  input  logic                            pktHdrEn,
  input  logic [PKT_HDR_BYTES*BYTE_W-1:0] pktHdr,
  input  logic                            addrCtlEn,
  input  logic [BYTE_W-1:0]               hdlcAddr,
  input  logic [BYTE_W-1:0]               hdlcCtrl,
  input  logic                            fcsEn,
  input  logic                            inValid,
  output logic                            inReady,
  input  logic [BYTE_W-1:0]               inData,
  input  logic                            inFirst,
  input  logic                            inLast,
  output logic                            outValid,
  input  logic                            outReady,
  output logic [BYTE_W-1:0]               outData,
  output logic                            outLast
);
  strobe_t          stb;
  logic             spaceOk;
  logic             oneByteLeft;
  logic [CNT_W-1:0] fillLevel;

  hdlc_encap_ctrl #(.PKT_HDR_BYTES(PKT_HDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .pktHdrEn(pktHdrEn), .pktHdr(pktHdr),
    .addrCtlEn(addrCtlEn), .hdlcAddr(hdlcAddr), .hdlcCtrl(hdlcCtrl), .fcsEn(fcsEn),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast), .inReady(inReady),
    .outReady(outReady), .spaceOk(spaceOk), .oneByteLeft(oneByteLeft),
    .outLast(outLast), .stb(stb)
  );

  hdlc_encap_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .outReady(outReady),
    .spaceOk(spaceOk), .oneByteLeft(oneByteLeft), .outValid(outValid),
    .outData(outData), .fillLevel(fillLevel)
  );
endmodule

// File: rtl/hdlc_encap_chk.sv
module hdlc_encap_chk #(
  parameter int FILL_W = 5,
  parameter int FILL_MAX = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        outData,
  input logic              outLast,
  input logic [FILL_W-1:0] fillLevel
);
  logic rstSeen = 1'b0;
  always_ff @(posedge clk) rstSeen <= !rstN;

  // R1: quiet output on the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rstSeen |-> (!outValid && !outLast));

  // R9: stalled output holds its byte and marker
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R9: bit store never exceeds its worst-case bound
  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FILL_W'(FILL_MAX));

  // R8: end marker only on a valid byte
  assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R8: nothing remains after the final byte is taken
  assert_last_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);
endmodule

bind hdlc_encap hdlc_encap_chk #(.FILL_W(hdlc_encap_pkg::CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outLast(outLast), .fillLevel(fillLevel)
);

// File: tb/test_hdlc_encap.sv
`timescale 1ns/1ps
module test_hdlc_encap;
  localparam int HB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteMode = 1'b0, pktHdrEn = 1'b0, addrCtlEn = 1'b0, fcsEn = 1'b0;
  logic [HB*8-1:0] pktHdr = '0;
  logic [7:0] hdlcAddr = '0, hdlcCtrl = '0, inData = '0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic inReady, outValid, outLast;
  logic outReady = 1'b1;
  logic [7:0] outData;

  always #5 clk = ~clk;

  hdlc_encap #(.PKT_HDR_BYTES(HB)) i_hdlc_encap (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .pktHdrEn(pktHdrEn), .pktHdr(pktHdr),
    .addrCtlEn(addrCtlEn), .hdlcAddr(hdlcAddr), .hdlcCtrl(hdlcCtrl), .fcsEn(fcsEn),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inFirst(inFirst),
    .inLast(inLast), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast)
  );

  int checks = 0, errors = 0, cycles = 0;
  int framesSeen = 0, lastCount = 0, lastPos = -1;
  logic [7:0] gotQ[$];
  logic [7:0] expQ[$];
  bit readyRandom = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // sink: record transfers, then pick a new ready value after the edge
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      gotQ.push_back(outData);
      if (outLast) begin
        lastCount++;
        lastPos = gotQ.size() - 1;
        framesSeen++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = readyRandom ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected below %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] patByte(input int k, input int seed);
    logic [7:0] tbl [8] = '{8'h7E, 8'hFF, 8'h7D, 8'h00, 8'hF8, 8'h1F, 8'h5A, 8'h3E};
    return tbl[(k * 3 + seed) % 8];
  endfunction

  task automatic buildExp(input bit m, input bit h, input bit a, input bit f, input int len,
                          input logic [7:0] pay [6], input logic [HB*8-1:0] ph,
                          input logic [7:0] ad, input logic [7:0] ct);
    logic [7:0] prot[$];
    logic [15:0] c;
    logic [7:0] v;
    bit bq[$];
    int ones;
    int j;
    expQ.delete();
    if (a) begin prot.push_back(ad); prot.push_back(ct); end
    for (int k = 0; k < len; k++) prot.push_back(pay[k]);
    c = 16'hFFFF;
    foreach (prot[p]) begin
      for (int i = 0; i < 8; i++) begin
        bit fb;
        fb = c[0] ^ prot[p][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    c = ~c;
    if (f) begin prot.push_back(c[7:0]); prot.push_back(c[15:8]); end
    if (m) begin
      if (h) for (int k = 0; k < HB; k++) expQ.push_back(ph[k*8 +: 8]);
      expQ.push_back(8'h7E);
      foreach (prot[p]) begin
        if (prot[p] == 8'h7E || prot[p] == 8'h7D) begin
          expQ.push_back(8'h7D);
          expQ.push_back(prot[p] ^ 8'h20);
        end else expQ.push_back(prot[p]);
      end
      expQ.push_back(8'h7E);
    end else begin
      if (h) for (int k = 0; k < HB; k++) for (int i = 0; i < 8; i++) bq.push_back(ph[k*8 + i]);
      for (int i = 0; i < 8; i++) bq.push_back(1'(8'h7E >> i));
      ones = 0;
      foreach (prot[p]) begin
        for (int i = 0; i < 8; i++) begin
          bq.push_back(prot[p][i]);
          if (prot[p][i]) begin
            ones++;
            if (ones == 5) begin bq.push_back(1'b0); ones = 0; end
          end else ones = 0;
        end
      end
      for (int i = 0; i < 8; i++) bq.push_back(1'(8'h7E >> i));
      j = 0;
      while (bq.size() % 8 != 0) begin bq.push_back(1'(8'h7E >> j)); j++; end
      for (int k = 0; k < bq.size() / 8; k++) begin
        for (int i = 0; i < 8; i++) v[i] = bq[k*8 + i];
        expQ.push_back(v);
      end
    end
  endtask

  task automatic sendFrame(input bit m, input bit h, input bit a, input bit f,
                           input int len, input int seed);
    logic [7:0] pay [6];
    logic [HB*8-1:0] ph;
    int target, bad;
    string tag;
    for (int k = 0; k < 6; k++) pay[k] = patByte(k, seed);
    ph = {8'hC3 ^ 8'(seed), 8'h7E, 8'hA5};
    buildExp(m, h, a, f, len, pay, ph, 8'hFF, 8'h7D);
    target = framesSeen + 1;
    gotQ.delete();
    lastCount = 0;
    lastPos = -1;
    byteMode = m; pktHdrEn = h; addrCtlEn = a; fcsEn = f;
    pktHdr = ph; hdlcAddr = 8'hFF; hdlcCtrl = 8'h7D;
    for (int k = 0; k < len; k++) begin
      inValid = 1'b1; inFirst = (k == 0); inData = pay[k]; inLast = (k == len - 1);
      @(negedge clk);
      while (!inReady) @(negedge clk);
      @(posedge clk);
      #2;
      if (k == 0) begin  // R11: disturb the sampled options mid-frame
        byteMode = !m; pktHdrEn = !h; addrCtlEn = !a; fcsEn = !f;
        pktHdr = ~ph; hdlcAddr = 8'h00; hdlcCtrl = 8'h7E;
      end
    end
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
    while (framesSeen < target) @(negedge clk);
    tag = m ? "R2 R5 R9 R11" : "R2 R6 R7 R9 R11";
    if (a) tag = {tag, " R3"};
    if (f) tag = {tag, " R4"};
    bad = -1;
    if (gotQ.size() == expQ.size()) begin
      foreach (expQ[i]) if (bad < 0 && gotQ[i] !== expQ[i]) bad = i;
    end
    if (gotQ.size() != expQ.size())
      check(1'b0, {tag, " frame length"}, gotQ.size(), expQ.size());
    else if (bad >= 0)
      check(1'b0, $sformatf("%s byte %0d", tag, bad), gotQ[bad], expQ[bad]);
    else
      check(1'b1, tag, 0, 0);
    check(lastCount == 1 && lastPos == expQ.size() - 1, "R8 end marker position",
          lastPos, expQ.size() - 1);
  endtask

  int seed = 0;
  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !outLast, "R1 output idle after reset", {outValid, outLast}, 0);
    check(!inReady, "R1 inReady low in idle", inReady, 0);

    // R10: stray byte without start marker is swallowed
    @(posedge clk); #2;
    inValid = 1'b1; inFirst = 1'b0; inData = 8'h55; inLast = 1'b1;
    @(negedge clk);
    check(inReady, "R10 stray byte accepted", inReady, 1);
    @(posedge clk); #2;
    inValid = 1'b0; inLast = 1'b0;
    repeat (6) @(negedge clk);
    check(!outValid && gotQ.size() == 0, "R10 stray byte produced no output",
          gotQ.size(), 0);
    @(posedge clk); #2;

    for (int r = 0; r < 2; r++) begin
      readyRandom = (r == 1);
      for (int m = 0; m < 2; m++)
        for (int opt = 0; opt < 8; opt++)
          for (int len = 1; len <= 6; len++) begin
            sendFrame(m[0], opt[2], opt[1], opt[0], len, seed);
            seed++;
          end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule